// File: doc/BRIEF.md
# Clock-Failure Interrupt and Status Register

This block collects the health signals of a clock-generation subsystem: one failure flag per input clock, the PLL lock indication and the PLL busy indication. It keeps them in an 8-bit status word that a host processor reads through a simple register-read port. That port stands in for a serial management bus. When enabled, the block pulls an active-low, open-drain interrupt line to call the host. The host then reads the status word. Its top bit tells the host whether this block raised the interrupt, and the other bits tell it why. The read itself acknowledges the interrupt.

The block also holds the device configuration word: switching mode, primary input, two bank divider codes, bank enables and interrupt enable. While master reset is low this word is reloaded every cycle, and the value present at release is kept. With the preset pin low, everything loads as zero and the block counts as unconfigured until the host writes a configuration. With the preset pin high, the block loads a ready-to-run set and counts as configured. A PLL that reports loss of lock while not busy, once configured, is a catastrophic failure. It is latched until the next master reset.

Top module: `clkmon_irq_status`

## Requirements
- R1: While `mrst_n` is low with `preset_sel` low, the configuration word loads 0x0000. After release the status word reads 0x04 (unconfigured, so bit 2 is set), and `irq_n` is released (not driven).
- R2: While `mrst_n` is low with `preset_sel` high, the configuration word loads 0x207F. The layout is: bit 13 automatic switching, bits 12:11 primary input (0), bits 10:8 divider code for banks A/B (0 = divide by 2), bits 7:5 divider code for banks C/D (3 = divide by 8), bits 4:1 bank enables (all 1), bit 0 interrupt enable (1). After release the status word reads 0x01.
- R3: Status bit 3+i is set at the clock edge where `clk_fail[i]` is high. It stays set until a read, even after the input drops.
- R4: Status bit 2 (out of lock) is 1 after any edge where `pll_unlock` is high, where the block is unconfigured, or where the catastrophic latch is set. Otherwise it is 0.
- R5: Status bit 7 (interrupt flag) is set by a rising edge of any `clk_fail` input or of the bit-2 condition, but only while the interrupt-enable bit is 1. One edge after the enable bit reads 0, the flag is 0.
- R6: `irq_n` is driven 0 exactly while status bit 7 is set, and is high-impedance otherwise.
- R7: `rd_data` always shows the current status word. A cycle with `rd_stb` high returns the pre-clear value, then clears bit 7 and every failure bit whose input is low.
- R8: A new failure or out-of-lock edge in the same cycle as a read leaves bit 7 set.
- R9: Once configured, `pll_unlock` high with `pll_busy` low sets status bit 1 (catastrophic). The bit and status bit 2 then stay 1 until master reset, whatever the inputs do. Before any configuration this condition does not set bit 1.
- R10: A cycle with `cfg_we` high loads `cfg_wdata` into the configuration word at that edge and marks the block configured (status bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mrst_n | input | 1 | Master reset, active low, sampled synchronously |
| preset_sel | input | 1 | Selects the ready-to-run configuration loaded during master reset |
| clk_fail | input | 4 | Per-input clock failure flags |
| pll_unlock | input | 1 | PLL lock indication, 1 = not locked |
| pll_busy | input | 1 | PLL acquiring lock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 14 | Configuration write data |
| cfg_word | output | 14 | Current configuration word |
| rd_stb | input | 1 | Status read strobe (clear on read) |
| rd_data | output | 8 | Status word |
| irq_n | output | 1 | Open-drain interrupt, driven 0 when active, high-impedance otherwise |

## Verification
The status path is driven with single-channel failures, failures that persist across a read, a second channel that rises during a read, and lock loss with busy high and busy low. Between them these patterns separate sticky failure bits from the edge-triggered flag, a plain acknowledge from a same-cycle new event, and ordinary lock loss from the catastrophic latch. Both reset flavours are applied. The preset-low run also shows that the enable bit gates the flag, that the catastrophic detector waits for configuration, and that disabling interrupts withdraws a pending flag.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    parameter int NCLK  = 4;
    parameter int NBANK = 4;
    parameter int DIV_W = 3;
    localparam int SEL_W  = $clog2(NCLK);
    localparam int STAT_W = NCLK + 4;

    // status word bit positions
    localparam int ST_DONE   = 0;
    localparam int ST_CAT    = 1;
    localparam int ST_UNLOCK = 2;
    localparam int ST_FAIL0  = 3;
    localparam int ST_FLAG   = STAT_W - 1;

    // divider codes: divide ratio = 2 * (code + 1)
    localparam logic [DIV_W-1:0] DIV_BY2 = DIV_W'(0);
    localparam logic [DIV_W-1:0] DIV_BY8 = DIV_W'(3);

    typedef struct packed {
        logic              auto_sw;
        logic [SEL_W-1:0]  prim_sel;
        logic [DIV_W-1:0]  div_ab;
        logic [DIV_W-1:0]  div_cd;
        logic [NBANK-1:0]  bank_en;
        logic              irq_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic cfg_t boot_cfg(input logic preset);
        cfg_t c;
        c = '0;
        if (preset) begin
            c.auto_sw  = 1'b1;
            c.prim_sel = '0;
            c.div_ab   = DIV_BY2;
            c.div_cd   = DIV_BY8;
            c.bank_en  = '1;
            c.irq_en   = 1'b1;
        end
        return c;
    endfunction
endpackage

// File: rtl/clkmon_cfg.sv
module clkmon_cfg
    import clkmon_pkg::*;
(
    input  logic       clk,
    input  logic       mrst_n,
    input  logic       preset_sel,
    input  logic       cfg_we,
    input  cfg_t       cfg_wdata,
    output cfg_t       cfg_q_o,
    output logic       cfg_done_o
);
    typedef struct packed {
        cfg_t cfg;
        logic done;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mrst_n) begin
            // reload every reset cycle; value present at release is kept
            st_d.cfg  = boot_cfg(preset_sel);
            st_d.done = preset_sel;
        end else if (cfg_we) begin
            st_d.cfg  = cfg_wdata;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cfg_q_o    = st_q.cfg;
    assign cfg_done_o = st_q.done;
endmodule

// File: rtl/clkmon_status.sv
module clkmon_status
    import clkmon_pkg::*;
(
    input  logic              clk,
    input  logic              mrst_n,
    input  logic [NCLK-1:0]   clk_fail,
    input  logic              pll_unlock,
    input  logic              pll_busy,
    input  logic              irq_en,
    input  logic              cfg_done,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_act_o
);
    typedef struct packed {
        logic            flag;
        logic [NCLK-1:0] fail;
        logic            unlock;
        logic            cat;
        logic [NCLK-1:0] fail_prev;
        logic            lock_prev;
    } st_t;

    st_t st_d, st_q;

    logic [NCLK-1:0] fail_rise;
    logic            cat_next;
    logic            lock_bad;
    logic            lock_rise;
    logic            any_event;

    // per-channel edge detection
    for (genvar i = 0; i < NCLK; i++) begin : g_edge
        assign fail_rise[i] = clk_fail[i] & ~st_q.fail_prev[i];
    end

    assign cat_next  = st_q.cat | (cfg_done & pll_unlock & ~pll_busy);
    assign lock_bad  = pll_unlock | ~cfg_done | cat_next;
    assign lock_rise = lock_bad & ~st_q.lock_prev;
    assign any_event = (|fail_rise) | lock_rise;

    always_comb begin
        st_d = st_q;
        if (!mrst_n) begin
            st_d.flag      = 1'b0;
            st_d.fail      = '0;
            st_d.unlock    = 1'b1;
            st_d.cat       = 1'b0;
            st_d.fail_prev = '0;
            st_d.lock_prev = 1'b1;
        end else begin
            st_d.cat       = cat_next;
            st_d.unlock    = lock_bad;
            st_d.fail      = (rd_stb ? '0 : st_q.fail) | clk_fail;
            st_d.flag      = irq_en & ((st_q.flag & ~rd_stb) | any_event);
            st_d.fail_prev = clk_fail;
            st_d.lock_prev = lock_bad;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stat_o    = {st_q.flag, st_q.fail, st_q.unlock, st_q.cat, cfg_done};
    assign irq_act_o = st_q.flag;
endmodule

// File: rtl/clkmon_irq_status.sv
module clkmon_irq_status
    import clkmon_pkg::*;
(
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              preset_sel,
    input  logic [NCLK-1:0]   clk_fail,
    input  logic              pll_unlock,
    input  logic              pll_busy,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_word,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq_n
);
    cfg_t cfg_q;
    logic cfg_done;
    logic irq_act;

    clkmon_cfg u_cfg (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .preset_sel (preset_sel),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_t'(cfg_wdata)),
        .cfg_q_o    (cfg_q),
        .cfg_done_o (cfg_done)
    );

    clkmon_status u_stat (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .clk_fail   (clk_fail),
        .pll_unlock (pll_unlock),
        .pll_busy   (pll_busy),
        .irq_en     (cfg_q.irq_en),
        .cfg_done   (cfg_done),
        .rd_stb     (rd_stb),
        .stat_o     (rd_data),
        .irq_act_o  (irq_act)
    );

    assign cfg_word = cfg_q;

    // open-drain: pull low when active, release otherwise
    assign irq_n = irq_act ? 1'b0 : 1'bz;
endmodule

// File: rtl/clkmon_irq_status_chk.sv
module clkmon_irq_status_chk
    import clkmon_pkg::*;
(
    input logic              clk,
    input logic              mrst_n,
    input logic [NCLK-1:0]   clk_fail,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [CFG_W-1:0]  cfg_word,
    input logic              rd_stb,
    input logic [STAT_W-1:0] rd_data,
    input logic              irq_n
);
    AST_FAIL_SET: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> ((rd_data[ST_FAIL0 +: NCLK] & $past(clk_fail)) == $past(clk_fail))); // R3

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
        !rd_stb |=> ((rd_data[ST_FAIL0 +: NCLK] & $past(rd_data[ST_FAIL0 +: NCLK]))
                     == $past(rd_data[ST_FAIL0 +: NCLK]))); // R3

    AST_CAT_LOCK: assert property (@(posedge clk) disable iff (!mrst_n)
        rd_data[ST_CAT] |-> rd_data[ST_UNLOCK]); // R4

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!mrst_n)
        !cfg_word[0] |=> !rd_data[ST_FLAG]); // R5

    AST_IRQ_PIN: assert property (@(posedge clk) disable iff (!mrst_n)
        (irq_n == 1'b0) == rd_data[ST_FLAG]); // R6

    AST_CAT_STICKY: assert property (@(posedge clk) disable iff (!mrst_n)
        rd_data[ST_CAT] |=> rd_data[ST_CAT]); // R9

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!mrst_n)
        cfg_we |=> (cfg_word == $past(cfg_wdata)) && rd_data[ST_DONE]); // R10
endmodule

bind clkmon_irq_status clkmon_irq_status_chk u_chk (.*);

// File: tb/sim_clkmon_irq_status.sv
module sim_clkmon_irq_status;
    import clkmon_pkg::*;

    logic              clk = 1'b0;
    logic              mrst_n = 1'b0;
    logic              preset_sel = 1'b1;
    logic [NCLK-1:0]   clk_fail = '0;
    logic              pll_unlock = 1'b0;
    logic              pll_busy = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [CFG_W-1:0]  cfg_word;
    logic              rd_stb = 1'b0;
    logic [STAT_W-1:0] rd_data;
    wire               irq_n;

    pullup (irq_n);

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    clkmon_irq_status u0 (
        .clk(clk), .mrst_n(mrst_n), .preset_sel(preset_sel), .clk_fail(clk_fail),
        .pll_unlock(pll_unlock), .pll_busy(pll_busy), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_word(cfg_word), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    // vector: {rd, fail[3:0], unlock, busy, expected status[7:0], expected irq low}
    localparam int NV = 15;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 4'b0000, 1'b0, 1'b0, 8'h01, 1'b0},  // idle after preset
        {1'b0, 4'b0001, 1'b0, 1'b0, 8'h89, 1'b1},  // R3 R5 ch0 fails
        {1'b0, 4'b0001, 1'b0, 1'b0, 8'h89, 1'b1},  // held
        {1'b0, 4'b0000, 1'b0, 1'b0, 8'h89, 1'b1},  // R3 sticky
        {1'b1, 4'b0000, 1'b0, 1'b0, 8'h01, 1'b0},  // R7 read clears
        {1'b0, 4'b0100, 1'b0, 1'b0, 8'hA1, 1'b1},  // ch2 fails
        {1'b1, 4'b0100, 1'b0, 1'b0, 8'h21, 1'b0},  // R7 still failed, flag cleared
        {1'b1, 4'b0110, 1'b0, 1'b0, 8'hB1, 1'b1},  // R8 new edge during read
        {1'b1, 4'b0000, 1'b0, 1'b0, 8'h01, 1'b0},  // clear all
        {1'b0, 4'b0000, 1'b1, 1'b1, 8'h85, 1'b1},  // R4 unlock while busy
        {1'b1, 4'b0000, 1'b1, 1'b1, 8'h05, 1'b0},  // level, no new edge
        {1'b0, 4'b0000, 1'b0, 1'b1, 8'h01, 1'b0},  // relocked
        {1'b0, 4'b0000, 1'b1, 1'b0, 8'h87, 1'b1},  // R9 catastrophic
        {1'b1, 4'b0000, 1'b0, 1'b0, 8'h07, 1'b0},  // R9 sticky through read
        {1'b0, 4'b0000, 1'b0, 1'b0, 8'h07, 1'b0}   // R9 still sticky
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick_check(input string req, input logic [7:0] es, input logic el);
        @(posedge clk);
        #1;
        chk(req, {24'h0, rd_data}, {24'h0, es});
        chk({req, " irq"}, {31'h0, irq_n}, {31'h0, ~el});
    endtask

    task automatic do_reset(input logic pre);
        @(negedge clk);
        mrst_n = 1'b0;
        preset_sel = pre;
        repeat (3) @(negedge clk);
        mrst_n = 1'b1;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // preset-high reset
        do_reset(1'b1);
        @(posedge clk); #1;
        chk("R2 cfg", {18'h0, cfg_word}, 32'h207F);
        chk("R2 stat", {24'h0, rd_data}, 32'h01);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rd_stb     = VEC[i][15];
            clk_fail   = VEC[i][14:11];
            pll_unlock = VEC[i][10];
            pll_busy   = VEC[i][9];
            tick_check($sformatf("vec%0d R3/R5/R7/R8/R9", i), VEC[i][8:1], VEC[i][0]);
        end
        @(negedge clk);
        rd_stb = 1'b0;

        // preset-low reset with unlock high and busy low: R1, R9 qualifier
        pll_unlock = 1'b1;
        pll_busy   = 1'b0;
        clk_fail   = '0;
        do_reset(1'b0);
        @(posedge clk); #1;
        chk("R1 cfg", {18'h0, cfg_word}, 32'h0);
        chk("R1 stat", {24'h0, rd_data}, 32'h04);
        chk("R1 irq", {31'h0, irq_n}, 32'h1);

        // R5: interrupt disabled, failure recorded but no flag
        @(negedge clk); clk_fail = 4'b0001;
        tick_check("R5 gated", 8'h0C, 1'b0);

        // R10 write config, R4 bit 2 drops once configured
        @(negedge clk); clk_fail = '0; pll_unlock = 1'b0; cfg_we = 1'b1; cfg_wdata = 14'h0001;
        @(posedge clk); #1;
        chk("R10 cfg", {18'h0, cfg_word}, 32'h0001);
        @(negedge clk); cfg_we = 1'b0;
        tick_check("R4 R10 configured", 8'h09, 1'b0);

        // R5 R6 enabled failure on ch3
        @(negedge clk); clk_fail = 4'b1000;
        tick_check("R5 R6 ch3", 8'hC9, 1'b1);

        // R7 pre-clear read data
        @(negedge clk); clk_fail = '0; rd_stb = 1'b1;
        #1;
        chk("R7 read value", {24'h0, rd_data}, 32'hC9);
        tick_check("R7 cleared", 8'h01, 1'b0);

        // R5 disabling interrupts withdraws the flag
        @(negedge clk); rd_stb = 1'b0; clk_fail = 4'b0100;
        tick_check("R5 ch2", 8'hA1, 1'b1);
        @(negedge clk); clk_fail = '0; cfg_we = 1'b1; cfg_wdata = 14'h0000;
        tick_check("R5 write", 8'hA1, 1'b1);
        @(negedge clk); cfg_we = 1'b0;
        tick_check("R5 disabled", 8'h21, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule